// File: doc/BRIEF.md
# Key Tone and First-Key Dial Lock Guard

This block sits between a debounced keypad decoder and the dialing logic of a telephone dialer. Each key event arrives as a one-cycle strobe with a key code and a flag that says more than one key was held. The block decides whether the event is a valid key. It forwards valid keys to the dialing logic one cycle later. For each valid key it also starts a short square-wave burst on the key-tone output, so the user hears that the key was taken.

The block also applies a call-barring policy for private exchanges. A two-bit lock setting chooses which leading digits are barred. Only the first key after reset, or the first key after the handset goes on hook, is checked against the policy. If that first key is barred, it is swallowed, and the block then refuses every later key until the next reset. The tone is made by dividing the system clock. The length of the burst is counted on an external 1 ms tick.

Top module: `key_tone_guard`

## Requirements
- R1: An accepted key gives `key_out_vld` high for exactly one cycle, in the cycle after the input strobe, with `key_out_code` equal to the input code.
- R2: The key tone starts high in the same cycle that the forwarded strobe appears. It then toggles every CLK_HZ/(2*TONE_HZ) clock cycles.
- R3: The burst ends at the clock edge where the BURST_MS-th `tick_1ms` pulse after the key is sampled. From that edge on, `tone_out` is low.
- R4: `tone_out` stays low whenever no burst is running.
- R5: A strobe with `multi_key` high produces neither a forwarded strobe nor a tone. It also does not count as the first key.
- R6: Lock setting encoding on `lock_sel`:
  - 2'b00 bars nothing.
  - 2'b01 bars a first key with code 0.
  - 2'b10 and 2'b11 bar a first key with code 0 or code 9.
  - Codes 0 to 9 are the digits of the same value. Codes 10 and above are function keys and are never barred.
- R7: A barred first key produces neither a forwarded strobe nor a tone. After it, every later key is ignored until reset, and going on hook does not clear this.
- R8: Only the first accepted-or-barred key is checked. A barred digit that comes later is forwarded normally.
- R9: While `on_hook` is high, keys are ignored, and a running burst stops at the next edge. Going on hook also re-arms the first-key check for the next call.
- R10: While `rst_n` is low, and right after it is released, `key_out_vld` and `tone_out` are low.

Tone and burst timing:

| Quantity | Value |
|---|---|
| Tone half-period | CLK_HZ/(2*TONE_HZ) clock cycles |
| Burst length | BURST_MS ticks of `tick_1ms` |

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| key_vld | input | 1 | One-cycle strobe of a debounced key event |
| key_code | input | CODE_W | Code of the key (0-9 digits, 10+ function keys) |
| multi_key | input | 1 | More than one key held during the event |
| lock_sel | input | 2 | Barring policy selector |
| on_hook | input | 1 | High while the handset is on hook |
| tick_1ms | input | 1 | One-cycle pulse every millisecond |
| key_out_vld | output | 1 | Forwarded key strobe to the dialing logic |
| key_out_code | output | CODE_W | Code of the forwarded key |
| tone_out | output | 1 | Key confirmation square wave |

## Verification
The bench focuses on the first-key rule.

- **Multi-key before a barred digit.** A multi-key event comes first, then a barred digit. A design that counted the multi-key event as the first key would let the barred digit through.
- **First key is a function key.** A function key is pressed first, then a barred digit. A design that checked every key instead of only the first would drop the later digit.
- **Lockout across a hook cycle.** After a barred first key, the handset goes on hook and off hook again. A design that tied the lockout to the hook state would start forwarding keys again.
- **Burst edges.** The bench counts the high cycles of the tone inside the burst and checks the single cycles on either side of the final tick. A divider that is off by one, or a burst counter that ends one tick early or late, shows up here.

// File: rtl/key_tone_pkg.sv
package key_tone_pkg;

  typedef enum logic [1:0] {
    LK_OPEN      = 2'b00,
    LK_ZERO      = 2'b01,
    LK_ZERO_NINE = 2'b10,
    LK_STRICT    = 2'b11
  } lock_e;

  // Number of clock cycles per tone half-period.
  function automatic int unsigned tone_half_cycles(input int unsigned clk_hz,
                                                   input int unsigned tone_hz);
    return clk_hz / (2 * tone_hz);
  endfunction

  // True when a leading key with this code is barred under this policy.
  function automatic logic digit_barred(input lock_e lk, input int unsigned code);
    logic bar;
    unique case (lk)
      LK_OPEN:                bar = 1'b0;
      LK_ZERO:                bar = (code == 0);
      LK_ZERO_NINE, LK_STRICT: bar = (code == 0) || (code == 9);
      default:                bar = 1'b0;
    endcase
    return bar;
  endfunction

endpackage

// File: rtl/key_lock_guard.sv
module key_lock_guard
  import key_tone_pkg::*;
#(
  parameter int CODE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_vld,
  input  logic [CODE_W-1:0] key_code,
  input  logic              multi_key,
  input  logic [1:0]        lock_sel,
  input  logic              on_hook,
  output logic              accept,
  output logic              first_seen,
  output logic              locked_out
);

  logic key_try;
  logic barred_now;
  logic block_first;

  // A usable single-key event while off hook and not locked out.
  assign key_try     = key_vld && !multi_key && !on_hook && !locked_out;
  assign barred_now  = digit_barred(lock_e'(lock_sel), int'(key_code));
  assign block_first = key_try && !first_seen && barred_now;
  assign accept      = key_try && !block_first;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      first_seen <= 1'b0;
      locked_out <= 1'b0;
    end else begin
      if (on_hook) begin
        first_seen <= 1'b0;
      end else if (key_try) begin
        first_seen <= 1'b1;
      end
      if (block_first) begin
        locked_out <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/key_tone_osc.sv
module key_tone_osc #(
  parameter int HALF     = 1491,
  parameter int BURST_MS = 35
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic kill,
  input  logic tick,
  output logic tone,
  output logic active
);

  localparam int DIV_W = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int MS_W  = (BURST_MS > 1) ? $clog2(BURST_MS) : 1;

  logic             lvl;
  logic [DIV_W-1:0] div_cnt;
  logic [MS_W-1:0]  ms_cnt;
  logic             half_done;
  logic             burst_done;

  assign half_done  = (div_cnt == DIV_W'(HALF - 1));
  assign burst_done = tick && (ms_cnt == MS_W'(BURST_MS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active  <= 1'b0;
      lvl     <= 1'b0;
      div_cnt <= '0;
      ms_cnt  <= '0;
    end else if (kill) begin
      active <= 1'b0;
      lvl    <= 1'b0;
    end else if (start) begin
      active  <= 1'b1;
      lvl     <= 1'b1;
      div_cnt <= '0;
      ms_cnt  <= '0;
    end else if (active) begin
      if (half_done) begin
        div_cnt <= '0;
        lvl     <= ~lvl;
      end else begin
        div_cnt <= div_cnt + 1'b1;
      end
      if (burst_done) begin
        active <= 1'b0;
        lvl    <= 1'b0;
      end else if (tick) begin
        ms_cnt <= ms_cnt + 1'b1;
      end
    end
  end

  assign tone = active && lvl;

endmodule

// File: rtl/key_tone_guard.sv
module key_tone_guard
  import key_tone_pkg::*;
#(
  parameter int CODE_W   = 5,
  parameter int CLK_HZ   = 3579545,
  parameter int TONE_HZ  = 1200,
  parameter int BURST_MS = 35
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_vld,
  input  logic [CODE_W-1:0] key_code,
  input  logic              multi_key,
  input  logic [1:0]        lock_sel,
  input  logic              on_hook,
  input  logic              tick_1ms,
  output logic              key_out_vld,
  output logic [CODE_W-1:0] key_out_code,
  output logic              tone_out
);

  localparam int HALF = int'(tone_half_cycles(CLK_HZ, TONE_HZ));

  // Internal events brought out for the checker.
  logic accept;
  logic first_seen;
  logic locked_out;
  logic burst_on;

  key_lock_guard #(.CODE_W(CODE_W)) u_guard (
    .clk        (clk),
    .rst_n      (rst_n),
    .key_vld    (key_vld),
    .key_code   (key_code),
    .multi_key  (multi_key),
    .lock_sel   (lock_sel),
    .on_hook    (on_hook),
    .accept     (accept),
    .first_seen (first_seen),
    .locked_out (locked_out)
  );

  key_tone_osc #(.HALF(HALF), .BURST_MS(BURST_MS)) u_osc (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (accept),
    .kill   (on_hook),
    .tick   (tick_1ms),
    .tone   (tone_out),
    .active (burst_on)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      key_out_vld  <= 1'b0;
      key_out_code <= '0;
    end else begin
      key_out_vld <= accept;
      if (accept) begin
        key_out_code <= key_code;
      end
    end
  end

endmodule

module key_tone_guard_chk #(
  parameter int CODE_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              key_vld,
  input logic [CODE_W-1:0] key_code,
  input logic              multi_key,
  input logic [1:0]        lock_sel,
  input logic              on_hook,
  input logic              first_seen,
  input logic              locked_out,
  input logic              key_out_vld,
  input logic              tone_out
);

  // R5
  multi_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    key_vld && multi_key |=> !key_out_vld);

  // R9
  hook_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    on_hook |=> !key_out_vld && !tone_out);

  // R7
  lockout_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked_out |=> !key_out_vld);

  // R7
  lockout_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked_out |=> locked_out);

  // R6
  first_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    key_vld && !multi_key && !on_hook && !first_seen && (key_code == '0)
      && (lock_sel != 2'b00) |=> !key_out_vld && locked_out);

  // R2
  tone_with_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    key_out_vld |-> tone_out);

endmodule

bind key_tone_guard key_tone_guard_chk #(.CODE_W(CODE_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .key_vld     (key_vld),
  .key_code    (key_code),
  .multi_key   (multi_key),
  .lock_sel    (lock_sel),
  .on_hook     (on_hook),
  .first_seen  (first_seen),
  .locked_out  (locked_out),
  .key_out_vld (key_out_vld),
  .tone_out    (tone_out)
);

// File: tb/key_tone_guard_test.sv
module key_tone_guard_test;

  localparam int CODE_W   = 5;
  localparam int CLK_HZ   = 24000;
  localparam int TONE_HZ  = 1200;
  localparam int BURST_MS = 35;
  localparam int MS_CYC   = 10;
  localparam int HALF_EXP = 10;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              key_vld = 1'b0;
  logic [CODE_W-1:0] key_code = '0;
  logic              multi_key = 1'b0;
  logic [1:0]        lock_sel = 2'b00;
  logic              on_hook = 1'b0;
  logic              tick_1ms = 1'b0;
  logic              key_out_vld;
  logic [CODE_W-1:0] key_out_code;
  logic              tone_out;

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  always #5 clk = ~clk;

  key_tone_guard #(
    .CODE_W(CODE_W), .CLK_HZ(CLK_HZ), .TONE_HZ(TONE_HZ), .BURST_MS(BURST_MS)
  ) uut (
    .clk(clk), .rst_n(rst_n), .key_vld(key_vld), .key_code(key_code),
    .multi_key(multi_key), .lock_sel(lock_sel), .on_hook(on_hook),
    .tick_1ms(tick_1ms), .key_out_vld(key_out_vld),
    .key_out_code(key_out_code), .tone_out(tone_out)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] lk);
    @(negedge clk);
    rst_n = 1'b0; key_vld = 1'b0; multi_key = 1'b0; on_hook = 1'b0;
    tick_1ms = 1'b0; lock_sel = lk;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Drive one key strobe; sample outputs after the capturing edge.
  task automatic press(input int code, input bit multi,
                       output bit vld, output int got_code, output bit tone);
    key_vld = 1'b1; key_code = CODE_W'(code); multi_key = multi;
    @(posedge clk);
    @(negedge clk);
    key_vld = 1'b0; multi_key = 1'b0;
    vld = key_out_vld; got_code = int'(key_out_code); tone = tone_out;
  endtask

  task automatic watch(input int n, output int highs, output int strobes);
    highs = 0; strobes = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (tone_out) highs++;
      if (key_out_vld) strobes++;
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check(!key_out_vld && !tone_out, "R10 in reset", int'(key_out_vld | tone_out), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!key_out_vld && !tone_out, "R10 after release", int'(key_out_vld | tone_out), 0);
  endtask

  task automatic t_forward_and_tone;
    bit v; int c; bit t; int hi; int st; int exp_hi; int burst_hi; bit last_in; bit first_out;
    do_reset(2'b00);
    press(5, 1'b0, v, c, t);
    check(v, "R1 strobe", int'(v), 1);
    check(c == 5, "R1 code", c, 5);
    check(t, "R2 tone starts high", int'(t), 1);
    @(negedge clk);
    check(!key_out_vld, "R1 single-cycle strobe", int'(key_out_vld), 0);
    // Samples t=2..HALF-1 high, then HALF low.
    watch(HALF_EXP - 2, hi, st);
    check(hi == HALF_EXP - 2, "R2 first half high", hi, HALF_EXP - 2);
    watch(HALF_EXP, hi, st);
    check(hi == 0, "R2 second half low", hi, 0);
    watch(HALF_EXP, hi, st);
    check(hi == HALF_EXP, "R2 third half high", hi, HALF_EXP);
    // Restart burst and measure its length in ticks.
    press(7, 1'b0, v, c, t);
    check(v && c == 7 && t, "R1 second key", c, 7);
    burst_hi = 0; last_in = 1'b0; first_out = 1'b1;
    for (int ms = 1; ms <= BURST_MS; ms++) begin
      for (int k = 0; k < MS_CYC; k++) begin
        tick_1ms = (k == MS_CYC - 1);
        @(posedge clk);
        @(negedge clk);
        if (ms == BURST_MS && k == MS_CYC - 2) last_in = tone_out;
        if (ms == BURST_MS && k == MS_CYC - 1) first_out = tone_out;
        else if (tone_out) burst_hi++;
      end
    end
    tick_1ms = 1'b0;
    exp_hi = 0;
    for (int s = 1; s < BURST_MS * MS_CYC; s++) if (((s / HALF_EXP) % 2) == 0) exp_hi++;
    check(burst_hi == exp_hi, "R2 high cycles in burst", burst_hi, exp_hi);
    check(last_in, "R3 still on before last tick", int'(last_in), 1);
    check(!first_out, "R3 off at last tick", int'(first_out), 0);
    watch(4 * MS_CYC, hi, st);
    check(hi == 0, "R4 idle after burst", hi, 0);
  endtask

  task automatic t_idle;
    int hi; int st;
    do_reset(2'b10);
    watch(60, hi, st);
    check(hi == 0 && st == 0, "R4 idle low without keys", hi + st, 0);
  endtask

  task automatic t_multi_then_barred;
    bit v; int c; bit t; int hi; int st;
    do_reset(2'b01);
    press(3, 1'b1, v, c, t);
    watch(15, hi, st);
    check(!v && !t && hi == 0 && st == 0, "R5 multi-key ignored", int'(v) + hi + st, 0);
    press(0, 1'b0, v, c, t);
    check(!v && !t, "R5 multi-key not first, 0 barred", int'(v | t), 0);
    press(4, 1'b0, v, c, t);
    watch(15, hi, st);
    check(!v && !t && hi == 0, "R7 later key ignored", int'(v) + hi, 0);
  endtask

  task automatic t_policies;
    bit v; int c; bit t; int hi; int st;
    do_reset(2'b00);
    press(0, 1'b0, v, c, t);
    check(v && c == 0, "R6 open lock passes 0", int'(v), 1);
    do_reset(2'b01);
    press(9, 1'b0, v, c, t);
    check(v && c == 9, "R6 zero lock passes 9", int'(v), 1);
    press(0, 1'b0, v, c, t);
    check(v && c == 0, "R8 later 0 forwarded", int'(v), 1);
    do_reset(2'b10);
    press(9, 1'b0, v, c, t);
    watch(15, hi, st);
    check(!v && !t && hi == 0, "R6 zero-nine lock bars 9", int'(v) + hi, 0);
    do_reset(2'b11);
    press(0, 1'b0, v, c, t);
    check(!v && !t, "R6 strict lock bars 0", int'(v | t), 0);
    do_reset(2'b10);
    press(10, 1'b0, v, c, t);
    check(v && c == 10, "R6 function key never barred", c, 10);
    press(9, 1'b0, v, c, t);
    check(v && c == 9, "R8 9 after function key", c, 9);
    // Reset lifts a lockout.
    do_reset(2'b01);
    press(0, 1'b0, v, c, t);
    check(!v, "R7 barred first 0", int'(v), 0);
    do_reset(2'b01);
    press(5, 1'b0, v, c, t);
    check(v && c == 5, "R7 reset clears lockout", c, 5);
  endtask

  task automatic t_hook;
    bit v; int c; bit t; int hi; int st;
    do_reset(2'b01);
    press(5, 1'b0, v, c, t);
    check(v, "R9 key before hook", int'(v), 1);
    on_hook = 1'b1;
    @(negedge clk);
    check(!tone_out, "R9 burst cut on hook", int'(tone_out), 0);
    press(6, 1'b0, v, c, t);
    check(!v && !t, "R9 key ignored on hook", int'(v | t), 0);
    on_hook = 1'b0;
    @(negedge clk);
    press(0, 1'b0, v, c, t);
    watch(15, hi, st);
    check(!v && !t && hi == 0, "R9 first-key check re-armed", int'(v) + hi, 0);
    on_hook = 1'b1;
    repeat (3) @(negedge clk);
    on_hook = 1'b0;
    @(negedge clk);
    press(5, 1'b0, v, c, t);
    check(!v && !t, "R7 lockout survives hook cycle", int'(v | t), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_forward_and_tone();
    t_idle();
    t_multi_then_barred();
    t_policies();
    t_hook();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule